// File: doc/BRIEF.md
# Memory-Mapped Periodic Interrupt Timer

This block is a timer that sits beside a processor's local interrupt logic and is programmed over a simple 32-bit memory-mapped bus. Software writes a control word, a divide code and a start value. A 32-bit down-counter then counts toward zero, stepping on ticks that a power-of-two prescaler takes from the bus clock. When the counter expires, the block raises a level interrupt request and presents an 8-bit vector beside it.

In periodic mode the counter reloads its start value on the tick that expires and keeps running. In one-shot mode it halts at zero after a single interrupt. The request stays up until software writes the end-of-interrupt register. An expiry that lands while a request is still unacknowledged is kept as a single pending bit and delivered after the acknowledge.

Top module: `periodic_irq_timer`

## Requirements
- R1: After reset, every readable register reads 0, the counter is stopped and `irq_req` is low.
- R2: Register map by byte offset. Control at 0x320 keeps bits 7:0 (vector), bit 16 (mask) and bit 17 (periodic), and reads back only those bits. Start value at 0x380 reads back all 32 bits. Divide code at 0x3E0 keeps and reads back bits 3:0. Live count at 0x390 is read-only, and writes to it are ignored.
- R3: The acknowledge register at 0x0B0 is write-only and reads 0. Every other unused offset also reads 0.
- R4: The divide code is {bit3, bit1, bit0}. Codes 000, 001, 010, 011, 100, 101 and 110 divide the clock by 2, 4, 8, 16, 32, 64 and 128. Code 111 divides by 1. Bit 2 has no effect.
- R5: A write of N to 0x380 loads the count and restarts the prescaler. With divide D, the first expiry happens on the N*D-th clock edge after the write edge, and `irq_req` is high after that edge.
- R6: In periodic mode, the counter reloads from the start value on the tick that reaches zero, so expiries are spaced exactly N*D clocks apart.
- R7: In one-shot mode, the live count reads 0 after the expiry. No further interrupt follows.
- R8: Writing 0 to 0x380 stops the counter at once. The live count reads 0 and no interrupt is raised.
- R9: With the mask bit set, expiries raise no request, but the counter keeps counting and reloading.
- R10: `irq_req` stays high until a write to 0x0B0. Expiries while it is high set one pending bit, so the request stays high across the next acknowledge. Any further expiries in that window are dropped, and a second acknowledge clears the request.
- R11: `irq_vector` always equals bits 7:0 of the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; also the timebase |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_req | output | 1 | Level interrupt request |
| irq_vector | output | 8 | Vector delivered with the request |

## Verification
A wrong prescaler phase or a counter that is off by one shows up as an interrupt one or more cycles away from N*D. This is visible on the first expiry after the start write, and the edge count after that write is checked exactly. A lost or stuck pending bit shows up on the acknowledge that follows two or three expiries: the request either drops too early or fails to drop on the second acknowledge. A reload that uses the wrong value shows up one period later as a wrong interval. It can also appear as a live count that does not step down by one between consecutive reads.

// File: rtl/tmr_regs_pkg.sv
package tmr_regs_pkg;

   localparam int VEC_W = 8;
   localparam int DIV_CODE_W = 4;

   localparam logic [11:0] OFF_ACK   = 12'h0B0;
   localparam logic [11:0] OFF_CTRL  = 12'h320;
   localparam logic [11:0] OFF_START = 12'h380;
   localparam logic [11:0] OFF_LIVE  = 12'h390;
   localparam logic [11:0] OFF_DIV   = 12'h3E0;

   typedef struct packed {
      logic             periodic;
      logic             mask;
      logic [VEC_W-1:0] vec;
   } tmr_ctrl_t;

   // Shift amount of the prescaler: code 111 -> 0 (divide by 1), else index+1
   function automatic logic [2:0] div_shift(input logic [DIV_CODE_W-1:0] code);
      logic [2:0] idx;
      idx = {code[3], code[1], code[0]};
      return (idx == 3'b111) ? 3'd0 : idx + 3'd1;
   endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int PRE_W = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart,
   input  logic [2:0] shift,
   output logic       tick
);

   generate
      if (PRE_W < 7) begin : g_pre_w_bad
         $error("tmr_prescaler: PRE_W must cover divide by 128");
      end
   endgenerate

   logic [PRE_W-1:0] pcnt_q;
   logic [PRE_W-1:0] phase_mask;

   always_comb begin
      phase_mask = PRE_W'((1 << shift) - 1);
      tick       = (pcnt_q & phase_mask) == phase_mask;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       pcnt_q <= '0;
      else if (restart) pcnt_q <= '0;
      else              pcnt_q <= pcnt_q + PRE_W'(1);
   end

   // R4
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && shift != 3'd0) |=> (!tick || shift != $past(shift)));

endmodule

// File: rtl/tmr_down_counter.sv
module tmr_down_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             periodic,
   input  logic             tick,
   output logic [CNT_W-1:0] count,
   output logic             expire
);

   logic [CNT_W-1:0] count_q;

   assign count  = count_q;
   assign expire = tick && (count_q == CNT_W'(1)) && !load;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (load) begin
         count_q <= load_val;
      end else if (tick && count_q != '0) begin
         if (count_q == CNT_W'(1)) count_q <= periodic ? reload_val : '0;
         else                      count_q <= count_q - CNT_W'(1);
      end
   end

   // R5
   step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && count_q > CNT_W'(1)) |=> count_q == $past(count_q) - CNT_W'(1));

   // R6
   reload_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && periodic) |=> count_q == $past(reload_val));

   // R7
   oneshot_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count_q == '0 && !load) |=> count_q == '0);

endmodule

// File: rtl/tmr_irq_latch.sv
module tmr_irq_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic ack,
   output logic req
);

   logic req_q, pend_q;
   logic req_d, pend_d;

   always_comb begin
      req_d  = req_q & ~ack;
      pend_d = pend_q;
      if (ack && pend_q) begin
         req_d  = 1'b1;
         pend_d = 1'b0;
      end
      if (fire) begin
         if (req_d) pend_d = 1'b1;
         else       req_d  = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         req_q  <= req_d;
         pend_q <= pend_d;
      end
   end

   assign req = req_q;

   // R10
   pend_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> req_q);

   // R10
   req_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_q) |-> $past(fire));

   // R10
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !pend_q && !fire) |=> !req_q);

endmodule

// File: rtl/periodic_irq_timer.sv
module periodic_irq_timer
   import tmr_regs_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int CNT_W  = 32,
   parameter int PRE_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq_req,
   output logic [VEC_W-1:0]  irq_vector
);

   localparam int DATA_W = 32;
   localparam logic [ADDR_W-1:0] A_ACK   = ADDR_W'(OFF_ACK);
   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
   localparam logic [ADDR_W-1:0] A_START = ADDR_W'(OFF_START);
   localparam logic [ADDR_W-1:0] A_LIVE  = ADDR_W'(OFF_LIVE);
   localparam logic [ADDR_W-1:0] A_DIV   = ADDR_W'(OFF_DIV);

   generate
      if (ADDR_W < 10) begin : g_addr_bad
         $error("periodic_irq_timer: ADDR_W too small for the register map");
      end
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_cnt_bad
         $error("periodic_irq_timer: CNT_W must lie in 2..32");
      end
   endgenerate

   tmr_ctrl_t              ctrl_q;
   logic [CNT_W-1:0]       start_q;
   logic [DIV_CODE_W-1:0]  div_q;
   logic                   wr_ctrl, wr_start, wr_div, wr_ack;
   logic                   tick, expire;
   logic [CNT_W-1:0]       live_cnt;

   assign wr_ctrl  = bus_we && bus_addr == A_CTRL;
   assign wr_start = bus_we && bus_addr == A_START;
   assign wr_div   = bus_we && bus_addr == A_DIV;
   assign wr_ack   = bus_we && bus_addr == A_ACK;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         start_q <= '0;
         div_q   <= '0;
      end else begin
         if (wr_ctrl)  ctrl_q  <= '{periodic: bus_wdata[17], mask: bus_wdata[16],
                                    vec: bus_wdata[VEC_W-1:0]};
         if (wr_start) start_q <= bus_wdata[CNT_W-1:0];
         if (wr_div)   div_q   <= bus_wdata[DIV_CODE_W-1:0];
      end
   end

   tmr_prescaler #(.PRE_W(PRE_W)) prescaler_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (wr_start),
      .shift   (div_shift(div_q)),
      .tick    (tick)
   );

   tmr_down_counter #(.CNT_W(CNT_W)) counter_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (wr_start),
      .load_val   (bus_wdata[CNT_W-1:0]),
      .reload_val (start_q),
      .periodic   (ctrl_q.periodic),
      .tick       (tick),
      .count      (live_cnt),
      .expire     (expire)
   );

   tmr_irq_latch irq_latch_i (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (expire && !ctrl_q.mask),
      .ack   (wr_ack),
      .req   (irq_req)
   );

   assign irq_vector = ctrl_q.vec;

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_CTRL)
         bus_rdata = {14'd0, ctrl_q.periodic, ctrl_q.mask, 8'd0, ctrl_q.vec};
      else if (bus_addr == A_START)
         bus_rdata = DATA_W'(start_q);
      else if (bus_addr == A_LIVE)
         bus_rdata = DATA_W'(live_cnt);
      else if (bus_addr == A_DIV)
         bus_rdata = DATA_W'(div_q);
   end

   // R8
   stop_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_start && bus_wdata[CNT_W-1:0] == '0) |=> (live_cnt == '0 && !$rose(irq_req)));

   // R9
   masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.mask && !irq_req) |=> !irq_req);

endmodule

// File: tb/periodic_irq_timer_tb.sv
`timescale 1ns/1ps
module periodic_irq_timer_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] addr = '0;
   logic        we = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;
   logic [7:0]  vec;
   int          nchk = 0;
   int          nerr = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   periodic_irq_timer dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
      .bus_wdata(wdata), .bus_rdata(rdata), .irq_req(irq), .irq_vector(vec)
   );

   function automatic int div_of(input logic [3:0] c);
      int idx;
      idx = {c[3], c[1], c[0]};
      return (idx == 7) ? 1 : (2 << idx);
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic ack_now();
      addr = 12'h0B0; wdata = '0; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      we = 1'b0; addr = a;
      #1 d = rdata;
   endtask

   task automatic wait_irq(input int start, input int lim, output int c);
      c = start;
      while (!irq && c < lim) begin
         @(negedge clk);
         c++;
      end
   endtask

   task automatic quiesce();
      wr(12'h380, 0);
      ack_now();
      ack_now();
   endtask

   initial begin
      logic [31:0] d, d2;
      int c;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(12'h320, d); check("R1 ctrl", d, 0);
      rd(12'h380, d); check("R1 start", d, 0);
      rd(12'h3E0, d); check("R1 div", d, 0);
      rd(12'h390, d); check("R1 live", d, 0);
      check("R1 irq", irq, 0);

      // R2 readback widths
      wr(12'h320, 32'hFFFF_FFFF); rd(12'h320, d); check("R2 ctrl bits", d, 32'h0003_00FF);
      wr(12'h320, 0);
      wr(12'h3E0, 32'hFFFF_FFF5); rd(12'h3E0, d); check("R2 div bits", d, 32'h5);
      wr(12'h380, 32'h1234_5678); rd(12'h380, d); check("R2 start", d, 32'h1234_5678);
      wr(12'h380, 0);
      wr(12'h390, 77); rd(12'h390, d); check("R2 live read-only", d, 0);
      // R3 zero reads
      rd(12'h0B0, d); check("R3 ack reads 0", d, 0);
      rd(12'h100, d); check("R3 unused 0x100", d, 0);
      rd(12'h3F0, d); check("R3 unused 0x3F0", d, 0);

      // R10 pending: start 6, div 1, periodic; expiries at edges 6, 12, 18
      wr(12'h3E0, 32'hB);
      wr(12'h320, 32'h0002_0021);
      wr(12'h380, 6);
      repeat (6) @(negedge clk);
      check("R5 first expiry", irq, 1);
      check("R11 vector", vec, 8'h21);
      repeat (14) @(negedge clk);
      ack_now();
      check("R10 pending kept", irq, 1);
      ack_now();
      check("R10 extra expiries dropped", irq, 0);
      repeat (2) @(negedge clk);
      check("R6 next period", irq, 1);
      quiesce();

      // R9 mask
      wr(12'h320, 32'h0003_0042);
      wr(12'h380, 4);
      repeat (20) @(negedge clk);
      check("R9 masked no irq", irq, 0);
      rd(12'h390, d);
      @(negedge clk);
      rd(12'h390, d2);
      check("R9 counter runs", d2, (d == 1) ? 32'd4 : d - 1);
      quiesce();

      // R8 stop on zero
      wr(12'h320, 32'h0002_0010);
      wr(12'h380, 5);
      repeat (2) @(negedge clk);
      wr(12'h380, 0);
      rd(12'h390, d); check("R8 live zero", d, 0);
      repeat (30) @(negedge clk);
      check("R8 no irq", irq, 0);

      // Random trials: R4 R5 R6 R7 R11
      process::self().srandom(32'd2718);
      for (int t = 0; t < 24; t++) begin
         logic [3:0] code;
         int n, dv;
         bit per;
         logic [7:0] v;
         code = 4'($urandom % 16);
         n    = 1 + int'($urandom % 16);
         per  = 1'($urandom % 2);
         v    = 8'($urandom);
         dv   = div_of(code);
         wr(12'h320, {14'd0, per, 1'b0, 8'd0, v});
         wr(12'h3E0, {28'd0, code});
         wr(12'h380, n);
         wait_irq(0, n * dv + 5, c);
         check($sformatf("R4 R5 interval code=%0h n=%0d", code, n), c, n * dv);
         check("R11 vector", vec, v);
         if (per) begin
            if (n * dv >= 2) begin
               ack_now();
               wait_irq(1, n * dv + 5, c);
               check("R6 periodic interval", c, n * dv);
            end
            quiesce();
         end else begin
            rd(12'h390, d); check("R7 halted at zero", d, 0);
            ack_now();
            repeat (2 * n * dv + 4) @(negedge clk);
            check("R7 single shot", irq, 0);
            ack_now();
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nchk++;
         nerr++;
         $display("FAIL R5 watchdog actual=expired expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

endmodule